// File: doc/BRIEF.md
# Periodic Tick Down-Counter

This block is a periodic down-counter with a small word-wide register port. Software sets a start value and a control word. Once enabled, the counter loads the start value and decrements on each count tick. A count tick is either every core clock or only the clock cycles in which an external reference strobe is high. When the count reaches zero, the block sets a sticky status flag. If requested, it also emits a one-cycle pulse that asks the core to take an exception.

The flag is cleared either by reading the control word or by writing the current-value register. A write to the current-value register also restarts the count from the start value. If the start value is zero at the point where a reload would occur, the timer disables itself. A constant calibration word supplied on an input pin can be read back through the same port.

Top module: `tick_down_timer`

## Requirements
- R1: After reset, the control word, the start value and the current value all read 0, and `pend_pulse` is low.
- R2: Register offsets (byte address, decoded in full): control 0x10, start value 0x14, current value 0x18, calibration 0x1C. The control word layout is: bit 0 run enable, bit 1 exception request on zero, bit 2 count source (1 = core clock, 0 = reference strobe), bit 16 sticky zero flag, and all other bits read 0. A control write changes only bits 2:0 and leaves the flag as it was.
- R3: A read of the control word returns the flag as it stands and clears it at the following edge. A zero reached in that same cycle sets the flag again, and the set wins over the clear.
- R4: While running, the count drops by one per tick. With bit 2 = 1 a tick is every cycle. With bit 2 = 0 a tick is a cycle with `ref_strobe` high. In a cycle carrying a control write, the count does not move.
- R5: A tick that moves the count from 1 to 0 sets the flag. If bit 1 is set, that tick also raises `pend_pulse` for exactly one cycle, in the cycle after the tick. The next tick reloads the start value, so events repeat every start+1 ticks.
- R6: A tick taken while the count is 0 and the start value is 0 clears the run enable without setting the flag or pulsing. Counting then stops.
- R7: Any write to the current-value register loads the start value into the count and clears the flag. The written data is ignored.
- R8: A control write that turns the run enable on loads the start value. A control write that flips bit 2 while the enable stays on also loads the start value.
- R9: The current value reads 0 while the run enable is off. It reads 0 in the cycle after the tick that reached zero.
- R10: The start value and the count are 24 bits wide, and bits 31:24 of both read 0. A write to the start value keeps only bits 23:0.
- R11: Offset 0x1C returns `calib_word` unchanged. Any unmapped offset reads 0, and a write to an unmapped offset changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (drives the read side effect) |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| ref_strobe | input | 1 | External reference tick, one cycle per tick |
| calib_word | input | 32 | Constant calibration word |
| pend_pulse | output | 1 | One-cycle exception request |

## Verification
The bench uses the default parameters: a 24-bit count and an 8-bit offset. Directed sequences write large values to probe the 24-bit truncation. In the random phase, start values stay below eight, so zero crossings, self-disables on a zero start value, and collisions between a flag read and a new zero all occur many times within a few thousand cycles. The reference strobe is randomised in every cycle, so both count sources are exercised while the enable and the source bit change under a running count.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;
    localparam int unsigned OFS_CTRL  = 32'h10;
    localparam int unsigned OFS_START = 32'h14;
    localparam int unsigned OFS_COUNT = 32'h18;
    localparam int unsigned OFS_CALIB = 32'h1C;

    localparam int unsigned CB_RUN    = 0;
    localparam int unsigned CB_REQ    = 1;
    localparam int unsigned CB_SRC    = 2;
    localparam int unsigned CB_ZFLAG  = 16;
endpackage

// File: rtl/tick_src_select.sv
module tick_src_select (
    input  logic run_en,
    input  logic src_core,
    input  logic ref_strobe,
    input  logic hold,
    output logic tick
);
    // a control write freezes the count for its own cycle
    always_comb begin
        tick = run_en && !hold && (src_core || ref_strobe);
    end
endmodule

// File: rtl/tick_counter.sv
module tick_counter #(
    parameter int unsigned CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load,
    input  logic [CNT_W-1:0] start_val,
    output logic [CNT_W-1:0] count,
    output logic             zero_evt,
    output logic             stop_req
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        zero_evt = 1'b0;
        stop_req = 1'b0;
        if (load) begin
            st_d.cnt = start_val;
        end else if (tick) begin
            if (st_q.cnt == ONE) begin
                st_d.cnt = '0;
                zero_evt = 1'b1;
            end else if (st_q.cnt == '0) begin
                if (start_val == '0) begin
                    stop_req = 1'b1;
                end else begin
                    st_d.cnt = start_val;
                end
            end else begin
                st_d.cnt = st_q.cnt - ONE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count = st_q.cnt;

    AST_LOAD_TAKES_START: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (st_q.cnt == $past(start_val)));                          // R8
    AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load && st_q.cnt > ONE) |=> (st_q.cnt == $past(st_q.cnt) - ONE)); // R4
    AST_ZERO_AFTER_EVT: assert property (@(posedge clk) disable iff (!rst_n)
        zero_evt |=> (st_q.cnt == '0));                                    // R9
endmodule

// File: rtl/tick_regs.sv
module tick_regs
    import tick_timer_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned CNT_W  = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [DATA_W-1:0] calib_word,
    input  logic [CNT_W-1:0]  count,
    input  logic              zero_evt,
    input  logic              stop_req,
    output logic              run_en,
    output logic              src_core,
    output logic              hold,
    output logic              load,
    output logic [CNT_W-1:0]  start_val,
    output logic              pend_pulse
);
    localparam int unsigned PAD_W = DATA_W - CNT_W;

    typedef struct packed {
        logic             run;
        logic             req;
        logic             src;
        logic             zflag;
        logic             pend;
        logic [CNT_W-1:0] start;
    } reg_state_t;

    reg_state_t st_d, st_q;
    logic sel_ctrl, sel_start, sel_count, sel_calib;
    logic wr_ctrl, wr_start, wr_count, rd_ctrl;
    logic unused_wdata_hi;

    assign unused_wdata_hi = ^bus_wdata[DATA_W-1:CNT_W];

    always_comb begin
        sel_ctrl  = (bus_addr == ADDR_W'(OFS_CTRL));
        sel_start = (bus_addr == ADDR_W'(OFS_START));
        sel_count = (bus_addr == ADDR_W'(OFS_COUNT));
        sel_calib = (bus_addr == ADDR_W'(OFS_CALIB));
        wr_ctrl   = bus_wr && sel_ctrl;
        wr_start  = bus_wr && sel_start;
        wr_count  = bus_wr && sel_count;
        rd_ctrl   = bus_rd && sel_ctrl;

        hold = wr_ctrl;
        load = wr_count
            || (wr_ctrl && bus_wdata[CB_RUN]
                && (!st_q.run || (bus_wdata[CB_SRC] != st_q.src)));

        st_d      = st_q;
        st_d.pend = zero_evt && st_q.req;
        if (wr_ctrl) begin
            st_d.run = bus_wdata[CB_RUN];
            st_d.req = bus_wdata[CB_REQ];
            st_d.src = bus_wdata[CB_SRC];
        end else if (stop_req) begin
            st_d.run = 1'b0;
        end
        if (wr_start) st_d.start = bus_wdata[CNT_W-1:0];
        if (rd_ctrl || wr_count) st_d.zflag = 1'b0;
        if (zero_evt) st_d.zflag = 1'b1;

        bus_rdata = '0;
        if (sel_ctrl) begin
            bus_rdata[CB_RUN]   = st_q.run;
            bus_rdata[CB_REQ]   = st_q.req;
            bus_rdata[CB_SRC]   = st_q.src;
            bus_rdata[CB_ZFLAG] = st_q.zflag;
        end else if (sel_start) begin
            bus_rdata = {{PAD_W{1'b0}}, st_q.start};
        end else if (sel_count) begin
            bus_rdata = st_q.run ? {{PAD_W{1'b0}}, count} : '0;
        end else if (sel_calib) begin
            bus_rdata = calib_word;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign run_en     = st_q.run;
    assign src_core   = st_q.src;
    assign start_val  = st_q.start;
    assign pend_pulse = st_q.pend;

    AST_FLAG_ON_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        zero_evt |=> st_q.zflag);                                          // R5
    AST_PEND_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.pend |=> !st_q.pend);                                         // R5
    AST_STOP_CLEARS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        stop_req |=> !st_q.run);                                           // R6
    AST_CTRL_KEEPS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && !zero_evt && !bus_rd) |=> (st_q.zflag == $past(st_q.zflag))); // R2
endmodule

// File: rtl/tick_down_timer.sv
module tick_down_timer #(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned CNT_W  = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              ref_strobe,
    input  logic [DATA_W-1:0] calib_word,
    output logic              pend_pulse
);
    logic             run_en, src_core, hold, load, tick;
    logic             zero_evt, stop_req;
    logic [CNT_W-1:0] start_val, count;

    tick_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .calib_word (calib_word),
        .count      (count),
        .zero_evt   (zero_evt),
        .stop_req   (stop_req),
        .run_en     (run_en),
        .src_core   (src_core),
        .hold       (hold),
        .load       (load),
        .start_val  (start_val),
        .pend_pulse (pend_pulse)
    );

    tick_src_select u_sel (
        .run_en     (run_en),
        .src_core   (src_core),
        .ref_strobe (ref_strobe),
        .hold       (hold),
        .tick       (tick)
    );

    tick_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .load      (load),
        .start_val (start_val),
        .count     (count),
        .zero_evt  (zero_evt),
        .stop_req  (stop_req)
    );

    AST_IDLE_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_en && !$past(run_en)) |-> !pend_pulse);                      // R6
endmodule

// File: tb/tick_down_timer_test.sv
`timescale 1ns/1ps
module tick_down_timer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0, ref_strobe = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] calib_word = 32'h4000_1234;
    logic        pend_pulse;
    int          nchk = 0, nfail = 0;

    always #2 clk = ~clk;

    tick_down_timer uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ref_strobe(ref_strobe), .calib_word(calib_word), .pend_pulse(pend_pulse)
    );

    // reference model, written from the requirements
    logic        m_run, m_req, m_src, m_flag, m_pend;
    logic [23:0] m_start, m_cnt;

    always @(posedge clk) begin
        logic cw, sw, nw, ld, tk, ev, sp;
        if (!rst_n) begin
            m_run = 0; m_req = 0; m_src = 0; m_flag = 0; m_pend = 0;
            m_start = 0; m_cnt = 0;
        end else begin
            cw = bus_wr && bus_addr == 8'h10;
            sw = bus_wr && bus_addr == 8'h14;
            nw = bus_wr && bus_addr == 8'h18;
            ld = nw || (cw && bus_wdata[0] && (!m_run || bus_wdata[2] != m_src));
            tk = m_run && !cw && (m_src || ref_strobe);
            ev = 0; sp = 0;
            if (ld) m_cnt = m_start;
            else if (tk) begin
                if (m_cnt == 1) begin m_cnt = 0; ev = 1; end
                else if (m_cnt == 0) begin
                    if (m_start == 0) sp = 1; else m_cnt = m_start;
                end else m_cnt = m_cnt - 1;
            end
            m_pend = ev && m_req;
            if ((bus_rd && bus_addr == 8'h10) || nw) m_flag = 0;
            if (ev) m_flag = 1;
            if (cw) begin m_run = bus_wdata[0]; m_req = bus_wdata[1]; m_src = bus_wdata[2]; end
            else if (sp) m_run = 0;
            if (sw) m_start = bus_wdata[23:0];
        end
    end

    function automatic logic [31:0] exp_rd(input logic [7:0] a);
        case (a)
            8'h10: exp_rd = {15'b0, m_flag, 13'b0, m_src, m_req, m_run};
            8'h14: exp_rd = {8'b0, m_start};
            8'h18: exp_rd = m_run ? {8'b0, m_cnt} : 32'h0;
            8'h1C: exp_rd = calib_word;
            default: exp_rd = 32'h0;
        endcase
    endfunction

    function automatic string tag_of(input logic [7:0] a);
        case (a)
            8'h10: tag_of = "R2";
            8'h14: tag_of = "R10";
            8'h18: tag_of = "R9";
            default: tag_of = "R11";
        endcase
    endfunction

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic op(input logic w, input logic r, input logic [7:0] a,
                      input logic [31:0] d, input logic t);
        @(negedge clk);
        bus_wr = w; bus_rd = r; bus_addr = a; bus_wdata = d; ref_strobe = t;
        #1;
        chk(bus_rdata == exp_rd(a), tag_of(a), bus_rdata, exp_rd(a));
        chk(pend_pulse == m_pend, "R5", {31'b0, pend_pulse}, {31'b0, m_pend});
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        op(1, 0, a, d, 0);
    endtask

    task automatic rd_lit(input logic [7:0] a, input logic [31:0] lit, input string tag);
        op(0, 1, a, 0, 0);
        chk(bus_rdata == lit, tag, bus_rdata, lit);
    endtask

    task automatic idle(input int n, input logic t);
        for (int i = 0; i < n; i++) op(0, 0, 8'h18, 0, t);
    endtask

    initial begin
        #(4 * 100000);
        nchk++; nfail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        // R1 reset state
        rd_lit(8'h10, 32'h0, "R1");
        rd_lit(8'h14, 32'h0, "R1");
        rd_lit(8'h18, 32'h0, "R1");
        chk(pend_pulse == 1'b0, "R1", {31'b0, pend_pulse}, 32'h0);
        // R10 truncation
        wr(8'h14, 32'hABCD_EF12);
        rd_lit(8'h14, 32'h00CD_EF12, "R10");
        // R2 only bits 2:0 writable
        wr(8'h10, 32'hFFFF_FFF8);
        rd_lit(8'h10, 32'h0, "R2");
        // R8 enable loads, R4 core-clock count
        wr(8'h10, 32'h5);
        rd_lit(8'h18, 32'h00CD_EF12, "R8");
        rd_lit(8'h18, 32'h00CD_EF11, "R4");
        // R8 source flip reloads, R4 reference strobe
        wr(8'h10, 32'h1);
        rd_lit(8'h18, 32'h00CD_EF12, "R8");
        idle(3, 0);
        rd_lit(8'h18, 32'h00CD_EF12, "R4");
        idle(2, 1);
        rd_lit(8'h18, 32'h00CD_EF10, "R4");
        // R5/R9/R3 wrap with start 3
        wr(8'h10, 32'h0);
        wr(8'h14, 32'h3);
        wr(8'h10, 32'h7);
        idle(3, 0);
        rd_lit(8'h18, 32'h0, "R9");
        chk(pend_pulse == 1'b1, "R5", {31'b0, pend_pulse}, 32'h1);
        rd_lit(8'h10, 32'h0001_0007, "R3");
        chk(pend_pulse == 1'b0, "R5", {31'b0, pend_pulse}, 32'h0);
        rd_lit(8'h10, 32'h0000_0007, "R3");
        // R7 current write clears flag
        idle(2, 0);
        wr(8'h18, 32'h1234);
        rd_lit(8'h10, 32'h0000_0007, "R7");
        wr(8'h14, 32'd100);
        idle(10, 0);
        wr(8'h18, 32'h0);
        rd_lit(8'h18, 32'd100, "R7");
        // R6 zero start stops the timer
        wr(8'h10, 32'h0);
        rd_lit(8'h18, 32'h0, "R9");
        op(0, 1, 8'h10, 0, 0);
        wr(8'h14, 32'h0);
        wr(8'h10, 32'h5);
        rd_lit(8'h10, 32'h5, "R6");
        rd_lit(8'h10, 32'h4, "R6");
        idle(3, 0);
        rd_lit(8'h10, 32'h4, "R6");
        // R11 calibration and unmapped
        rd_lit(8'h1C, 32'h4000_1234, "R11");
        rd_lit(8'h00, 32'h0, "R11");
        wr(8'h20, 32'hFFFF_FFFF);
        rd_lit(8'h14, 32'h0, "R11");
        rd_lit(8'h10, 32'h4, "R11");
        // R3 set wins over read clear, start 1
        wr(8'h14, 32'h1);
        wr(8'h10, 32'h7);
        idle(2, 0);
        rd_lit(8'h10, 32'h0001_0007, "R3");
        rd_lit(8'h10, 32'h0001_0007, "R3");
        rd_lit(8'h10, 32'h0000_0007, "R3");
        // random phase
        void'($urandom(32'h0005_EED1));
        for (int i = 0; i < 4000; i++) begin
            int unsigned r;
            logic [7:0] a;
            r = $urandom % 100;
            case ($urandom % 5)
                0: a = 8'h10; 1: a = 8'h14; 2: a = 8'h18; 3: a = 8'h1C;
                default: a = 8'h18;
            endcase
            if (r < 8)       op(1, 0, 8'h10, $urandom, $urandom % 2);
            else if (r < 13) op(1, 0, 8'h14, $urandom % 8, $urandom % 2);
            else if (r < 16) op(1, 0, 8'h18, $urandom, $urandom % 2);
            else if (r < 17) op(1, 0, 8'h24, $urandom, $urandom % 2);
            else if (r < 35) op(0, 1, 8'h10, 0, $urandom % 2);
            else             op(0, $urandom % 2, a, 0, $urandom % 2);
        end
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end
endmodule